// File: doc/BRIEF.md
# Serial Byte Transmitter with DMA Pacing

This block sends bytes on an asynchronous serial line using a fixed frame of one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts a fixed number of clock cycles, set by a parameter. A one-entry holding register sits in front of the frame shifter. While one frame is on the line, the next byte can wait in the holding register, so frames can follow each other with no idle time between them.

Two status outputs describe the state of the transmitter. `tx_empty` shows that the holding register can take a byte. `xfer_done` shows that the line has gone quiet after the last queued frame. When DMA pacing is switched on, the empty status drives the request line directly, so an external DMA engine can keep the holding register full without CPU help. When the transmitter is enabled, it first sends one idle frame time of high line before any data frame. Software clears `xfer_done` through `done_clr`. The block leaves that flag alone while data is written.

Top module: `uart_dma_tx`

## Requirements
- R1: While `tx_en` is low, `txd` is high, `tx_empty` is 1, `xfer_done` is 1, `wr_overrun` is 0 and `dma_req` is 0. Writes have no effect while `tx_en` is low.
- R2: After `tx_en` rises, the line stays high for exactly ten bit times. A byte queued during that time starts its start bit on the clock edge that ends the tenth bit time.
- R3: A frame is a start bit of 0, then data bits 0 to 7 in that order, then a stop bit of 1. Each bit lasts `CLKS_PER_BIT` clock cycles.
- R4: A write made while `tx_empty` is 1 is accepted and clears `tx_empty` on the next edge. `tx_empty` returns to 1 on the edge where the byte moves into the shifter.
- R5: `dma_req` equals `tx_en & dma_en & tx_empty`. A request is removed in the cycle after the write that refills the holding register.
- R6: If a byte is waiting when a stop bit ends, the next start bit begins on that same edge, so consecutive frames start exactly 10 × `CLKS_PER_BIT` cycles apart.
- R7: `xfer_done` stays 0 while queued frames follow each other. It goes to 1 on the edge that ends a stop bit when no byte is waiting.
- R8: `done_clr` clears `xfer_done` on the next edge, whether or not a data write happens in the same cycle. A completion event in the same cycle takes priority over the clear.
- R9: A write made while `tx_empty` is 0 is discarded and sets `wr_overrun`. The bit stays set until `tx_en` goes low. The discarded byte never appears on the line.
- R10: Dropping `tx_en` during a frame stops the frame on the next edge. The line then goes high and all flags return to their disabled values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_en | input | 1 | Transmitter enable |
| dma_en | input | 1 | Enables DMA pacing through `dma_req` |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to write |
| done_clr | input | 1 | Clears `xfer_done` |
| txd | output | 1 | Serial line, high when idle |
| tx_empty | output | 1 | The holding register can accept a byte |
| xfer_done | output | 1 | Transmission complete |
| dma_req | output | 1 | DMA request |
| wr_overrun | output | 1 | Sticky flag for a write that was discarded |

## Verification
The assertions check the following on every cycle:
- the disabled state;
- that an accepted write empties the request path;
- that a rejected write raises the overrun flag;
- that a load from the idle state drives a start bit;
- that a refill at the end of a stop bit starts the next frame with no gap;
- that `xfer_done` rises only when the line is idle and the holding register is empty;
- that the software clear takes effect.

Only the bench scenarios can show the following:
- the exact length of the idle preamble;
- the bit order and bit timing of all 256 byte values sent as one paced stream;
- that the discarded byte never reaches the line;
- the exact cycle where completion rises after the last frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_IDLE = 2'd1,
    ST_BUSY = 2'd2
  } tx_state_e;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = run && (cnt_q == CNT_LAST);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: a bit period ends once and then runs again from zero
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick)
    else $error("R3: bit ticks back to back");

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST)
    else $error("R3: bit counter out of range");
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              overrun
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;
  logic              ovr_q, ovr_d;
  logic              accept, reject;

  always_comb begin
    accept = enable && wr_en && !full_q;
    reject = enable && wr_en && full_q;
    if (!enable)     full_d = 1'b0;
    else if (accept) full_d = 1'b1;
    else if (take)   full_d = 1'b0;
    else             full_d = full_q;
    if (!enable)     ovr_d = 1'b0;
    else if (reject) ovr_d = 1'b1;
    else             ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (accept) data_q <= wr_data;
  end

  assign full    = full_q;
  assign data    = data_q;
  assign overrun = ovr_q;

  // R4: the shifter only takes a byte that is present
  a_r4_take_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full)
    else $error("R4: take from empty holding register");

  // R9: a rejected write leaves the held byte untouched
  a_r9_reject_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    enable && wr_en && full && !take |=> $stable(data))
    else $error("R9: rejected write changed held data");
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              frame_idle,
  output logic              txd
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  tx_state_e          state_q, state_d;
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic               tick;
  logic               busy;

  assign busy = (state_q == ST_BUSY);

  uart_tx_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) baud_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  always_comb begin
    state_d    = state_q;
    sreg_d     = sreg_q;
    bit_d      = bit_q;
    take       = 1'b0;
    frame_idle = 1'b0;
    if (!enable) begin
      state_d = ST_OFF;
      sreg_d  = '1;
      bit_d   = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          // idle preamble: one whole frame of high line
          state_d = ST_BUSY;
          sreg_d  = '1;
          bit_d   = '0;
        end
        ST_IDLE: begin
          if (hold_full) begin
            take    = 1'b1;
            state_d = ST_BUSY;
            sreg_d  = {1'b1, hold_data, 1'b0};
            bit_d   = '0;
          end
        end
        ST_BUSY: begin
          if (tick) begin
            if (bit_q == LAST_BIT) begin
              bit_d = '0;
              if (hold_full) begin
                take   = 1'b1;
                sreg_d = {1'b1, hold_data, 1'b0};
              end else begin
                state_d    = ST_IDLE;
                sreg_d     = '1;
                frame_idle = 1'b1;
              end
            end else begin
              sreg_d = {1'b1, sreg_q[FRAME_W-1:1]};
              bit_d  = bit_q + 1'b1;
            end
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      sreg_q  <= '1;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      sreg_q  <= sreg_d;
      bit_q   <= bit_d;
    end
  end

  assign txd = busy ? sreg_q[0] : 1'b1;

  // R3: a load from idle puts a start bit on the line
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    enable && state_q == ST_IDLE && hold_full |=> !txd)
    else $error("R3: no start bit after load");

  // R6: a refill at the end of a stop bit gives the next start bit with no gap
  a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    enable && busy && tick && bit_q == LAST_BIT && hold_full |=> !txd)
    else $error("R6: gap between queued frames");

  // R10: when the transmitter is disabled, the line is high on the next edge
  a_r10_off_high: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> txd)
    else $error("R10: line not released");
endmodule

// File: rtl/uart_dma_tx.sv
module uart_dma_tx #(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              dma_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              done_clr,
  output logic              txd,
  output logic              tx_empty,
  output logic              xfer_done,
  output logic              dma_req,
  output logic              wr_overrun
);
  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              frame_idle;
  logic              done_q, done_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  uart_tx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .enable  (tx_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data),
    .overrun (wr_overrun)
  );

  uart_tx_shift #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) shift_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .enable     (tx_en),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .take       (take),
    .frame_idle (frame_idle),
    .txd        (txd)
  );

  always_comb begin
    if (!tx_en)          done_d = 1'b1;
    else if (frame_idle) done_d = 1'b1;
    else if (done_clr)   done_d = 1'b0;
    else                 done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) done_q <= 1'b1;
    else             done_q <= done_d;
  end

  assign xfer_done = done_q;
  assign tx_empty  = !hold_full;
  assign dma_req   = tx_en && dma_en && !hold_full;

  // R1: disabled state on the next edge
  a_r1_disabled: assert property (@(posedge clk) disable iff (!rst_core_n)
    !tx_en |=> txd && tx_empty && xfer_done && !wr_overrun)
    else $error("R1: disabled state wrong");

  // R5: a serviced request is withdrawn by the refill
  a_r5_req_served: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_en && dma_req && wr_en |=> !tx_empty)
    else $error("R5: request not withdrawn");

  // R7: completion rises only with an idle line and an empty holding register
  a_r7_done_rise: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_en && $rose(xfer_done) |-> tx_empty && txd)
    else $error("R7: completion while data pending");

  // R8: the software clear works when no completion competes with it
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_en && done_clr && !frame_idle |=> !xfer_done)
    else $error("R8: clear ignored");

  // R9: a write to a full holding register sets the overrun flag
  a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_en && wr_en && !tx_empty |=> wr_overrun)
    else $error("R9: overrun not flagged");
endmodule

// File: tb/uart_dma_tx_tb.sv
module uart_dma_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int C          = 4;
  localparam int FRAME      = 10 * C;
  localparam int NSTREAM    = 256;
  localparam int RXMAX      = 300;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, dma_en, wr_en, done_clr;
  logic [7:0] wr_data;
  logic       txd, tx_empty, xfer_done, dma_req, wr_overrun;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_dma_tx #(.CLKS_PER_BIT(C), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dma_en(dma_en),
    .wr_en(wr_en), .wr_data(wr_data), .done_clr(done_clr),
    .txd(txd), .tx_empty(tx_empty), .xfer_done(xfer_done),
    .dma_req(dma_req), .wr_overrun(wr_overrun)
  );

  // line decoder, sampling at the middle of each bit
  logic [7:0] rx_byte [RXMAX];
  logic       rx_stop [RXMAX];
  int         rx_start [RXMAX];
  int         rx_n = 0;
  bit         dec_busy = 0;
  int         dec_phase = 0;
  logic [9:0] dec_bits = '0;

  always @(negedge clk) begin
    if (!dec_busy) begin
      if (rst_n === 1'b1 && txd === 1'b0 && rx_n < RXMAX) begin
        dec_busy  <= 1;
        dec_phase <= 1;
        rx_start[rx_n] <= cyc;
      end
    end else begin
      if (dec_phase % C == C/2) dec_bits[dec_phase / C] <= txd;
      if (dec_phase == 9*C + C/2) begin
        rx_byte[rx_n] <= dec_bits[8:1];
        rx_stop[rx_n] <= txd;
        rx_n     <= rx_n + 1;
        dec_busy <= 0;
      end
      dec_phase <= dec_phase + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 2000 && rx_n < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, idx, req_bad, done_bad, gap_bad, done_cyc;
    bit prev;
    rst_n = 0; tx_en = 0; dma_en = 0; wr_en = 0; done_clr = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset and disabled state
    chk(txd == 1, "R1 txd", txd, 1);
    chk(tx_empty == 1, "R1 tx_empty", tx_empty, 1);
    chk(xfer_done == 1, "R1 xfer_done", xfer_done, 1);
    chk(dma_req == 0, "R1 dma_req", dma_req, 0);
    chk(wr_overrun == 0, "R1 overrun", wr_overrun, 0);
    wr_data = 8'hFF; wr_en = 1;
    @(negedge clk); wr_en = 0;
    chk(tx_empty == 1, "R1 write ignored", tx_empty, 1);
    @(negedge clk);

    // paced stream of every byte value; clear coincides with the enable
    tx_en = 1; dma_en = 1; done_clr = 1; base = cyc;
    idx = 0; prev = 0; req_bad = 0; done_bad = 0;
    while (idx < NSTREAM) begin
      @(negedge clk);
      done_clr = 0; wr_en = 0;
      if (prev && dma_req) req_bad++;
      if (xfer_done) done_bad++;
      prev = 0;
      if (dma_req) begin
        wr_data = idx[7:0]; wr_en = 1; idx++; prev = 1;
      end
    end
    @(negedge clk); wr_en = 0;
    chk(req_bad == 0, "R5 request withdrawn after refill", req_bad, 0);
    chk(done_bad == 0, "R8 R7 done low during stream", done_bad, 0);
    for (int i = 0; i < 4000 && !xfer_done; i++) @(negedge clk);
    done_cyc = cyc;
    wait_rx(NSTREAM);
    chk(rx_n == NSTREAM, "R3 frame count", rx_n, NSTREAM);
    chk(rx_start[0] - base == FRAME + 1, "R2 preamble length", rx_start[0] - base, FRAME + 1);
    for (int i = 0; i < NSTREAM; i++) begin
      chk(rx_byte[i] == i[7:0] && rx_stop[i] == 1, "R3 byte value",
          int'(rx_byte[i]), i);
    end
    gap_bad = 0;
    for (int i = 0; i + 1 < NSTREAM; i++)
      if (rx_start[i+1] - rx_start[i] != FRAME) gap_bad++;
    chk(gap_bad == 0, "R6 back to back spacing", gap_bad, 0);
    chk(done_cyc == rx_start[NSTREAM-1] + FRAME, "R7 done at last stop end",
        done_cyc, rx_start[NSTREAM-1] + FRAME);
    chk(tx_empty == 1, "R4 empty after drain", tx_empty, 1);

    // R8: software clear
    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0;
    chk(xfer_done == 0, "R8 clear", xfer_done, 1'b0);

    // R4, R9: overrun with pacing off
    dma_en = 0;
    wr_data = 8'hA5; wr_en = 1;
    @(negedge clk);
    chk(tx_empty == 0, "R4 cleared by write", tx_empty, 0);
    wr_data = 8'h3C; wr_en = 1;
    @(negedge clk);
    chk(tx_empty == 1, "R4 set on move to shifter", tx_empty, 1);
    chk(wr_overrun == 1, "R9 overrun set", wr_overrun, 1);
    wr_data = 8'h96; wr_en = 1;
    @(negedge clk); wr_en = 0;
    chk(tx_empty == 0, "R4 held while shifting", tx_empty, 0);
    chk(dma_req == 0, "R5 no request with pacing off", dma_req, 0);
    chk(xfer_done == 0, "R7 done low while busy", xfer_done, 0);
    wait_rx(NSTREAM + 2);
    chk(rx_byte[NSTREAM] == 8'hA5, "R9 first byte", int'(rx_byte[NSTREAM]), 'hA5);
    chk(rx_byte[NSTREAM+1] == 8'h96, "R9 discarded byte absent",
        int'(rx_byte[NSTREAM+1]), 'h96);
    chk(rx_start[NSTREAM+1] - rx_start[NSTREAM] == FRAME, "R6 spacing",
        rx_start[NSTREAM+1] - rx_start[NSTREAM], FRAME);
    chk(wr_overrun == 1, "R9 sticky", wr_overrun, 1);
    repeat (2 * C) @(negedge clk);
    chk(xfer_done == 1, "R7 done after last frame", xfer_done, 1);

    // R10: abort mid frame
    wr_data = 8'h00; wr_en = 1;
    @(negedge clk); wr_en = 0;
    repeat (15) @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    chk(txd == 1, "R10 line high", txd, 1);
    chk(tx_empty == 1 && xfer_done == 1, "R10 flags reset",
        {tx_empty, xfer_done}, 3);
    chk(wr_overrun == 0, "R10 overrun cleared", wr_overrun, 0);
    wr_en = 1; wr_data = 8'h00;
    @(negedge clk); wr_en = 0;
    chk(tx_empty == 1 && wr_overrun == 0, "R1 disabled write ignored",
        {tx_empty, wr_overrun}, 2);
    begin
      int low = 0;
      for (int i = 0; i < 3 * FRAME; i++) begin
        @(negedge clk);
        if (txd != 1) low++;
      end
      chk(low == 0, "R1 line held high", low, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule